// File: doc/BRIEF.md
# PCM Voice Bus Master

This block drives a serial PCM voice bus toward a standard telephony codec, acting as the bus master. It derives a bit clock from the system clock with an integer divider. The bit clock is either the 2.048 MHz rate or the 2.000 MHz rate, and the block generates an 8 kHz frame sync from it. Each frame carries one to three back-to-back timeslots. A slot is either 8 bits wide, for companded samples, or 16 bits wide, for linear samples.

The block has two serial data pins, and each one is separately an output or an input. An output pin shifts out per-slot transmit words, MSB first. An input pin fills per-slot receive words. A one-cycle strobe marks the capture of the last active bit in each frame. The rate, slot width, slot count and pin directions are taken into use only at a frame start, so a change never splits a frame.

Top module: `pcm_voice_master`

## Requirements
- R1: `pcm_clk_o` has a period of DIV_FAST system cycles when the rate select is 1 and DIV_SLOW cycles when it is 0. In each period it is high for the first DIV/2 cycles (rounded down) and low for the rest.
- R2: A frame lasts 256 bit periods when the rate select is 1 and 250 when it is 0. `pcm_sync_o` is high for exactly one bit period, which starts at the rising bit-clock edge of the frame's first bit.
- R3: `pin_o` and `pin_oe_o` change only together with a rising edge of `pcm_clk_o`. `pin_i` is sampled, and the receive words change, only together with a falling edge.
- R4: Slots go back to back, MSB first. Slot n begins at bit n×8 in 8-bit mode and at bit n×16 in 16-bit mode. The MSB of slot 0 is on the pin during the sync bit period.
- R5: The transmit word of pin p, slot s is `tx_data_i[(p*MAX_SLOTS+s)*16 +: 16]`, and the receive word uses the same position in `rx_data_o`. In 16-bit mode (`cfg_wide_i`=1) the whole word is used. In 8-bit mode only bits [7:0] are sent, and a received byte is stored in bits [7:0] with bits [15:8] set to zero.
- R6: The slot count, slot width, rate select and pin directions are latched at each frame start and held for the whole frame. A slot count of 0 is treated as 1, and a count above MAX_SLOTS is treated as MAX_SLOTS.
- R7: `pin_dir_i[p]`=1 makes pin p an output. An output pin has `pin_oe_o` high only during active slots. At every other time, and always on an input pin, `pin_oe_o` and `pin_o` are 0.
- R8: The receive words of an input pin are written for each active slot. The words of an output pin, and the words of slots beyond the active count, keep their values.
- R9: `frame_done_o` goes high for exactly one cycle per frame, in the cycle after the falling edge that captures the last bit of the last active slot.
- R10: In reset every output is 0. The first frame starts on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fast_i | input | 1 | 1: 2.048 MHz / 256-bit frame, 0: 2.000 MHz / 250-bit frame |
| cfg_wide_i | input | 1 | 1: 16-bit slots, 0: 8-bit slots |
| cfg_slots_i | input | SLOT_CW | Active slot count |
| pin_dir_i | input | NUM_PINS | Per-pin direction, 1 = output |
| tx_data_i | input | NUM_PINS*MAX_SLOTS*16 | Transmit words per pin and slot |
| pin_i | input | NUM_PINS | Serial data in |
| pcm_clk_o | output | 1 | Bit clock |
| pcm_sync_o | output | 1 | Frame sync |
| pin_o | output | NUM_PINS | Serial data out |
| pin_oe_o | output | NUM_PINS | Output enable per pin |
| rx_data_o | output | NUM_PINS*MAX_SLOTS*16 | Receive words per pin and slot |
| frame_done_o | output | 1 | Frame-complete strobe |

## Verification
The bench builds the block with DIV_FAST=4 and DIV_SLOW=6, which keeps a frame to 1024 or 1500 system cycles. With frames that short, about twenty of them fit in one run, and that is enough to cover both rates, both slot widths, every slot count and every direction pattern. The default MAX_SLOTS=3 is kept, so the full-frame case and the clamping of the slot count are both reached. The two pins are looped back to each other crosswise. Every receive word can then be predicted from the other pin's transmit word, or is zero when neither pin drives.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned NARROW_W = 8;

  typedef struct packed {
    logic fast;
    logic wide;
  } pcm_mode_t;

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_voice_pkg::*;
#(
  parameter int unsigned DIV_FAST   = 125,
  parameter int unsigned DIV_SLOW   = 128,
  parameter int unsigned FRAME_FAST = 256,
  parameter int unsigned FRAME_SLOW = 250,
  parameter int unsigned NUM_PINS   = 2,
  parameter int unsigned MAX_SLOTS  = 3,
  parameter int unsigned SLOT_CW    = 2,
  parameter int unsigned PH_W       = 7,
  parameter int unsigned BIT_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_fast_i,
  input  logic                cfg_wide_i,
  input  logic [SLOT_CW-1:0]  cfg_slots_i,
  input  logic [NUM_PINS-1:0] pin_dir_i,
  output logic                rise_en_o,
  output logic                fall_en_o,
  output logic [BIT_W-1:0]    next_bit_o,
  output pcm_mode_t           mode_nx_o,
  output logic [SLOT_CW-1:0]  slots_nx_o,
  output logic [NUM_PINS-1:0] dir_nx_o,
  output logic                wide_q_o,
  output logic [NUM_PINS-1:0] dir_q_o,
  output logic                pcm_clk_o,
  output logic                pcm_sync_o
);

  logic [PH_W-1:0]     ph_q, ph_d, ph_last, ph_half;
  logic [BIT_W-1:0]    bit_q, bit_d, bit_last;
  pcm_mode_t           mode_q, mode_d, mode_in;
  logic [SLOT_CW-1:0]  slots_q, slots_d, slots_in;
  logic [NUM_PINS-1:0] dir_q, dir_d;
  logic                clk_q, clk_d, sync_q, sync_d;
  logic                rise, fall, wrap;

  // The slot count is clamped into the legal range before it is latched
  always_comb begin
    slots_in = cfg_slots_i;
    if (cfg_slots_i == '0) begin
      slots_in = SLOT_CW'(1);
    end else if (cfg_slots_i > SLOT_CW'(MAX_SLOTS)) begin
      slots_in = SLOT_CW'(MAX_SLOTS);
    end
    mode_in.fast = cfg_fast_i;
    mode_in.wide = cfg_wide_i;
  end

  assign ph_last  = mode_q.fast ? PH_W'(DIV_FAST - 1)     : PH_W'(DIV_SLOW - 1);
  assign ph_half  = mode_q.fast ? PH_W'(DIV_FAST / 2 - 1) : PH_W'(DIV_SLOW / 2 - 1);
  assign bit_last = mode_q.fast ? BIT_W'(FRAME_FAST - 1)  : BIT_W'(FRAME_SLOW - 1);

  assign rise = (ph_q == ph_last);
  assign fall = (ph_q == ph_half);
  assign wrap = rise && (bit_q == bit_last);

  always_comb begin
    ph_d    = ph_q + PH_W'(1);
    bit_d   = bit_q;
    mode_d  = mode_q;
    slots_d = slots_q;
    dir_d   = dir_q;
    clk_d   = clk_q;
    sync_d  = sync_q;
    if (rise) begin
      ph_d   = '0;
      clk_d  = 1'b1;
      sync_d = wrap;
      if (wrap) begin
        bit_d   = '0;
        mode_d  = mode_in;
        slots_d = slots_in;
        dir_d   = pin_dir_i;
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end else if (fall) begin
      clk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_W'(DIV_FAST - 1);
      bit_q       <= BIT_W'(FRAME_FAST - 1);
      mode_q.fast <= 1'b1;
      mode_q.wide <= 1'b0;
      slots_q     <= SLOT_CW'(1);
      dir_q       <= '0;
      clk_q       <= 1'b0;
      sync_q      <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      mode_q  <= mode_d;
      slots_q <= slots_d;
      dir_q   <= dir_d;
      clk_q   <= clk_d;
      sync_q  <= sync_d;
    end
  end

  assign rise_en_o  = rise;
  assign fall_en_o  = fall;
  assign next_bit_o = bit_d;
  assign mode_nx_o  = mode_d;
  assign slots_nx_o = slots_d;
  assign dir_nx_o   = dir_d;
  assign wide_q_o   = mode_q.wide;
  assign dir_q_o    = dir_q;
  assign pcm_clk_o  = clk_q;
  assign pcm_sync_o = sync_q;

endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq #(
  parameter int unsigned SLOT_CW = 2,
  parameter int unsigned SLOT_IW = 2,
  parameter int unsigned BIT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_en_i,
  input  logic               fall_en_i,
  input  logic [BIT_W-1:0]   next_bit_i,
  input  logic               wide_nx_i,
  input  logic [SLOT_CW-1:0] slots_nx_i,
  output logic               act_nx_o,
  output logic [SLOT_IW-1:0] slot_nx_o,
  output logic               first_nx_o,
  output logic               act_q_o,
  output logic [SLOT_IW-1:0] slot_q_o,
  output logic               last_q_o,
  output logic               frame_done_o
);

  logic [BIT_W-1:0]   span;
  logic [3:0]         bpos;
  logic               act_nx, last_nx, final_nx;
  logic [SLOT_IW-1:0] slot_nx;
  logic               act_q, act_d, last_q, last_d, final_q, final_d, done_q, done_d;
  logic [SLOT_IW-1:0] slot_q, slot_d;

  // Decode of the bit that starts on the coming rising edge
  always_comb begin
    span     = BIT_W'(slots_nx_i) << (wide_nx_i ? 4 : 3);
    bpos     = wide_nx_i ? next_bit_i[3:0] : {1'b0, next_bit_i[2:0]};
    slot_nx  = SLOT_IW'(wide_nx_i ? (next_bit_i >> 4) : (next_bit_i >> 3));
    act_nx   = (next_bit_i < span);
    last_nx  = act_nx && (bpos == (wide_nx_i ? 4'd15 : 4'd7));
    final_nx = act_nx && (next_bit_i == span - BIT_W'(1));
  end

  always_comb begin
    act_d   = act_q;
    slot_d  = slot_q;
    last_d  = last_q;
    final_d = final_q;
    if (rise_en_i) begin
      act_d   = act_nx;
      slot_d  = slot_nx;
      last_d  = last_nx;
      final_d = final_nx;
    end
    done_d = fall_en_i && final_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      slot_q  <= '0;
      last_q  <= 1'b0;
      final_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      act_q   <= act_d;
      slot_q  <= slot_d;
      last_q  <= last_d;
      final_q <= final_d;
      done_q  <= done_d;
    end
  end

  assign act_nx_o     = act_nx;
  assign slot_nx_o    = slot_nx;
  assign first_nx_o   = (bpos == 4'd0);
  assign act_q_o      = act_q;
  assign slot_q_o     = slot_q;
  assign last_q_o     = last_q;
  assign frame_done_o = done_q;

endmodule

// File: rtl/pcm_lane.sv
module pcm_lane
  import pcm_voice_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 3,
  parameter int unsigned SLOT_IW   = 2,
  parameter int unsigned LANE_W    = MAX_SLOTS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_en_i,
  input  logic               fall_en_i,
  input  logic               dir_nx_i,
  input  logic               dir_q_i,
  input  logic               wide_nx_i,
  input  logic               wide_q_i,
  input  logic               act_nx_i,
  input  logic [SLOT_IW-1:0] slot_nx_i,
  input  logic               first_nx_i,
  input  logic               act_q_i,
  input  logic [SLOT_IW-1:0] slot_q_i,
  input  logic               last_q_i,
  input  logic [LANE_W-1:0]  tx_words_i,
  input  logic               pin_i,
  output logic               pin_o,
  output logic               pin_oe_o,
  output logic [LANE_W-1:0]  rx_words_o
);

  logic [WORD_W-1:0] word_sel, aligned, cap;
  logic [WORD_W-1:0] tsh_q, tsh_d;
  logic [WORD_W-2:0] rsh_q, rsh_d;
  logic [LANE_W-1:0] rx_q, rx_d;
  logic              out_q, out_d, oe_q, oe_d;

  // Transmit word of the coming slot, left-aligned so bit 15 leaves first
  always_comb begin
    word_sel = '0;
    for (int s = 0; s < int'(MAX_SLOTS); s++) begin
      if (slot_nx_i == SLOT_IW'(s)) begin
        word_sel = tx_words_i[s*WORD_W +: WORD_W];
      end
    end
    aligned = wide_nx_i ? word_sel : {word_sel[NARROW_W-1:0], {NARROW_W{1'b0}}};
  end

  always_comb begin
    tsh_d = tsh_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (rise_en_i) begin
      if (act_nx_i && (dir_nx_i == 1'b1)) begin
        oe_d = 1'b1;
        if (first_nx_i) begin
          out_d = aligned[WORD_W-1];
          tsh_d = {aligned[WORD_W-2:0], 1'b0};
        end else begin
          out_d = tsh_q[WORD_W-1];
          tsh_d = {tsh_q[WORD_W-2:0], 1'b0};
        end
      end else begin
        oe_d  = 1'b0;
        out_d = 1'b0;
      end
    end
  end

  // Receive path, sampled on the falling bit-clock edge
  always_comb begin
    rsh_d = rsh_q;
    rx_d  = rx_q;
    cap   = wide_q_i ? {rsh_q, pin_i}
                     : {{NARROW_W{1'b0}}, rsh_q[NARROW_W-2:0], pin_i};
    if (fall_en_i && act_q_i && (dir_q_i == 1'b0)) begin
      rsh_d = {rsh_q[WORD_W-3:0], pin_i};
      if (last_q_i) begin
        for (int s = 0; s < int'(MAX_SLOTS); s++) begin
          if (slot_q_i == SLOT_IW'(s)) begin
            rx_d[s*WORD_W +: WORD_W] = cap;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh_q <= '0;
      rsh_q <= '0;
      rx_q  <= '0;
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tsh_q <= tsh_d;
      rsh_q <= rsh_d;
      rx_q  <= rx_d;
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_o      = out_q;
  assign pin_oe_o   = oe_q;
  assign rx_words_o = rx_q;

endmodule

// File: rtl/pcm_voice_master.sv
module pcm_voice_master
  import pcm_voice_pkg::*;
#(
  parameter int unsigned DIV_FAST   = 125,
  parameter int unsigned DIV_SLOW   = 128,
  parameter int unsigned FRAME_FAST = 256,
  parameter int unsigned FRAME_SLOW = 250,
  parameter int unsigned NUM_PINS   = 2,
  parameter int unsigned MAX_SLOTS  = 3,
  parameter int unsigned SLOT_CW    = $clog2(MAX_SLOTS + 1),
  parameter int unsigned BUS_W      = NUM_PINS * MAX_SLOTS * 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_fast_i,
  input  logic                cfg_wide_i,
  input  logic [SLOT_CW-1:0]  cfg_slots_i,
  input  logic [NUM_PINS-1:0] pin_dir_i,
  input  logic [BUS_W-1:0]    tx_data_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic                pcm_clk_o,
  output logic                pcm_sync_o,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [BUS_W-1:0]    rx_data_o,
  output logic                frame_done_o
);

  localparam int unsigned DIV_MAX   = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int unsigned FRAME_MAX = (FRAME_FAST > FRAME_SLOW) ? FRAME_FAST : FRAME_SLOW;
  localparam int unsigned PH_W      = $clog2(DIV_MAX);
  localparam int unsigned BIT_W     = $clog2(FRAME_MAX);
  localparam int unsigned SLOT_IW   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
  localparam int unsigned LANE_W    = MAX_SLOTS * WORD_W;

  logic                rise_en, fall_en;
  logic [BIT_W-1:0]    next_bit;
  pcm_mode_t           mode_nx;
  logic [SLOT_CW-1:0]  slots_nx;
  logic [NUM_PINS-1:0] dir_nx, dir_q;
  logic                wide_q;
  logic                act_nx, first_nx, act_q, last_q;
  logic [SLOT_IW-1:0]  slot_nx, slot_q;

  pcm_frame_timer #(
    .DIV_FAST  (DIV_FAST),
    .DIV_SLOW  (DIV_SLOW),
    .FRAME_FAST(FRAME_FAST),
    .FRAME_SLOW(FRAME_SLOW),
    .NUM_PINS  (NUM_PINS),
    .MAX_SLOTS (MAX_SLOTS),
    .SLOT_CW   (SLOT_CW),
    .PH_W      (PH_W),
    .BIT_W     (BIT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_fast_i (cfg_fast_i),
    .cfg_wide_i (cfg_wide_i),
    .cfg_slots_i(cfg_slots_i),
    .pin_dir_i  (pin_dir_i),
    .rise_en_o  (rise_en),
    .fall_en_o  (fall_en),
    .next_bit_o (next_bit),
    .mode_nx_o  (mode_nx),
    .slots_nx_o (slots_nx),
    .dir_nx_o   (dir_nx),
    .wide_q_o   (wide_q),
    .dir_q_o    (dir_q),
    .pcm_clk_o  (pcm_clk_o),
    .pcm_sync_o (pcm_sync_o)
  );

  pcm_slot_seq #(
    .SLOT_CW(SLOT_CW),
    .SLOT_IW(SLOT_IW),
    .BIT_W  (BIT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_en_i   (rise_en),
    .fall_en_i   (fall_en),
    .next_bit_i  (next_bit),
    .wide_nx_i   (mode_nx.wide),
    .slots_nx_i  (slots_nx),
    .act_nx_o    (act_nx),
    .slot_nx_o   (slot_nx),
    .first_nx_o  (first_nx),
    .act_q_o     (act_q),
    .slot_q_o    (slot_q),
    .last_q_o    (last_q),
    .frame_done_o(frame_done_o)
  );

  for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_lane
    pcm_lane #(
      .MAX_SLOTS(MAX_SLOTS),
      .SLOT_IW  (SLOT_IW)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_en_i (rise_en),
      .fall_en_i (fall_en),
      .dir_nx_i  (dir_nx[p]),
      .dir_q_i   (dir_q[p]),
      .wide_nx_i (mode_nx.wide),
      .wide_q_i  (wide_q),
      .act_nx_i  (act_nx),
      .slot_nx_i (slot_nx),
      .first_nx_i(first_nx),
      .act_q_i   (act_q),
      .slot_q_i  (slot_q),
      .last_q_i  (last_q),
      .tx_words_i(tx_data_i[p*LANE_W +: LANE_W]),
      .pin_i     (pin_i[p]),
      .pin_o     (pin_o[p]),
      .pin_oe_o  (pin_oe_o[p]),
      .rx_words_o(rx_data_o[p*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/pcm_voice_master_chk.sv
module pcm_voice_master_chk #(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned BUS_W    = 96
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pcm_clk_o,
  input logic                pcm_sync_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [BUS_W-1:0]    rx_data_o,
  input logic                frame_done_o
);

  a_r2_sync_rises_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_sync_o) |-> $rose(pcm_clk_o));

  a_r2_sync_falls_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pcm_sync_o) |-> $rose(pcm_clk_o));

  a_r3_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> $rose(pcm_clk_o));

  a_r3_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe_o) |-> $rose(pcm_clk_o));

  a_r3_rx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data_o) |-> $fell(pcm_clk_o));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> $fell(pcm_clk_o));

  for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe_o[p] |-> !pin_o[p]);
  end

endmodule

bind pcm_voice_master pcm_voice_master_chk #(
  .NUM_PINS(NUM_PINS),
  .BUS_W   (BUS_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pcm_clk_o   (pcm_clk_o),
  .pcm_sync_o  (pcm_sync_o),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .rx_data_o   (rx_data_o),
  .frame_done_o(frame_done_o)
);

// File: tb/pcm_voice_master_tb.sv
module pcm_voice_master_tb;

  localparam int DF = 4;
  localparam int DS = 6;
  localparam int NP = 2;
  localparam int MS = 3;
  localparam int BW = NP * MS * 16;

  // {seed[3:0], fast, wide, slots[1:0], dir[1:0]}
  localparam logic [9:0] VEC [8] = '{
    10'b0001_1_1_11_01,
    10'b0010_0_0_11_10,
    10'b0011_1_0_01_01,
    10'b0100_0_1_10_10,
    10'b0101_1_1_00_01,
    10'b0110_1_1_11_11,
    10'b0111_0_0_10_00,
    10'b1000_1_1_11_01
  };

  logic          clk, rst_n;
  logic          cfg_fast, cfg_wide;
  logic [1:0]    cfg_slots;
  logic [NP-1:0] pin_dir, pin_i, pin_o, pin_oe;
  logic [BW-1:0] tx_data, rx_data;
  logic          pcm_clk, pcm_sync, done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_rx [NP][MS];

  pcm_voice_master #(.DIV_FAST(DF), .DIV_SLOW(DS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fast_i(cfg_fast), .cfg_wide_i(cfg_wide),
    .cfg_slots_i(cfg_slots), .pin_dir_i(pin_dir), .tx_data_i(tx_data),
    .pin_i(pin_i), .pcm_clk_o(pcm_clk), .pcm_sync_o(pcm_sync), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .rx_data_o(rx_data), .frame_done_o(done)
  );

  // Crossed loopback between the two pins
  assign pin_i = {pin_o[0], pin_o[1]};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] txw(int seed, int p, int s);
    return 16'(((seed + 1) * 40503 + p * 8191 + s * 3119)) ^ 16'h5A3C;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_tx(input int seed);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < MS; s++)
        tx_data[(p*MS+s)*16 +: 16] = txw(seed, p, s);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic measure_bclk(output int hi, output int lo);
    hi = 0; lo = 0;
    while (pcm_clk) @(negedge clk);
    while (!pcm_clk) @(negedge clk);
    while (pcm_clk) begin hi++; @(negedge clk); end
    while (!pcm_clk) begin lo++; @(negedge clk); end
  endtask

  // From one sync rise to the next; optionally alters the slot count mid-frame
  task automatic measure_frame(input int flip_at, input logic [1:0] flip_val,
                               output int per, output int shi, output int oe0,
                               output int oe1, output int ndone, output int done_at);
    per = 0; shi = 0; oe0 = 0; oe1 = 0; ndone = 0; done_at = -1;
    while (pcm_sync) @(negedge clk);
    while (!pcm_sync) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      if (i > 0 && pcm_sync && shi < per) break;
      if (pcm_sync) shi++;
      if (pin_oe[0]) oe0++;
      if (pin_oe[1]) oe1++;
      if (done) begin ndone++; done_at = per; end
      if (per == flip_at) cfg_slots = flip_val;
      per++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, per, shi, oe0, oe1, nd, dat;
    rst_n = 1'b0;
    cfg_fast = 1'b1; cfg_wide = 1'b1; cfg_slots = 2'd3; pin_dir = 2'b01;
    load_tx(0);
    repeat (4) @(negedge clk);
    check("R10 reset outputs", {pcm_clk, pcm_sync, pin_o, pin_oe, done, |rx_data}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 first frame starts at once", {pcm_clk, pcm_sync}, 32'h3);
    check("R3 R4 slot0 MSB driven on first rise", {pin_oe[0], pin_o[0]}, {30'h0, 1'b1, txw(0, 0, 0)[15]});

    measure_bclk(hi, lo);
    check("R1 fast high cycles", hi, DF / 2);
    check("R1 fast low cycles", lo, DF - DF / 2);
    measure_frame(-1, 2'd0, per, shi, oe0, oe1, nd, dat);
    check("R2 fast frame period", per, 256 * DF);
    check("R2 fast sync width", shi, DF);
    check("R7 output pin oe span 3x16", oe0, 3 * 16 * DF);
    check("R7 input pin oe stays low", oe1, 0);
    check("R9 one done per frame", nd, 1);
    check("R9 done timing 3x16", dat, 47 * DF + DF / 2);

    cfg_fast = 1'b0; cfg_wide = 1'b0; cfg_slots = 2'd2;
    measure_frame(200, 2'd1, per, shi, oe0, oe1, nd, dat);
    check("R2 slow frame period", per, 250 * DS);
    check("R2 slow sync width", shi, DS);
    check("R6 mid-frame change ignored", oe0, 2 * 8 * DS);
    check("R9 done timing 2x8", dat, 15 * DS + DS / 2);
    measure_frame(-1, 2'd1, per, shi, oe0, oe1, nd, dat);
    check("R6 new count used next frame", oe0, 1 * 8 * DS);
    check("R9 done timing 1x8", dat, 7 * DS + DS / 2);
    measure_bclk(hi, lo);
    check("R1 slow high cycles", hi, DS / 2);
    check("R1 slow low cycles", lo, DS - DS / 2);

    // Table-driven data checks from a fresh reset
    rst_n = 1'b0;
    pin_dir = 2'b11; cfg_fast = 1'b1; cfg_wide = 1'b1; cfg_slots = 2'd3;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < MS; s++) exp_rx[p][s] = 16'h0;
    rst_n = 1'b1;
    for (int v = 0; v < 8; v++) begin
      int seed, ns;
      logic [15:0] val;
      wait_done();
      seed = int'(VEC[v][9:6]);
      cfg_fast = VEC[v][5]; cfg_wide = VEC[v][4];
      cfg_slots = VEC[v][3:2]; pin_dir = VEC[v][1:0];
      load_tx(seed);
      wait_done();
      ns = (VEC[v][3:2] == 2'd0) ? 1 : int'(VEC[v][3:2]);
      for (int p = 0; p < NP; p++) begin
        if (!VEC[v][p]) begin
          for (int s = 0; s < ns; s++) begin
            val = VEC[v][1-p] ? txw(seed, 1 - p, s) : 16'h0;
            if (!VEC[v][4]) val = val & 16'h00FF;
            exp_rx[p][s] = val;
          end
        end
      end
      for (int p = 0; p < NP; p++)
        for (int s = 0; s < MS; s++)
          check($sformatf("R4 R5 R6 R8 vec%0d pin%0d slot%0d", v, p, s),
                rx_data[(p*MS+s)*16 +: 16], exp_rx[p][s]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule